// File: doc/BRIEF.md
# Speculative Checkpoint Phase Controller

This block tracks the execution phase of a core that splits one program into two hardware threads. The ahead thread keeps fetching past long-latency misses and pushes the instructions that depend on them into deferred queues. The behind thread later replays those queues. The controller decides when the committed checkpoint is taken and when speculative checkpoints are opened. It hands out ring indices for the deferred queues and their speculative register files. It also drives commits, thread sync, failure restarts and the switch into a prefetch-only scout mode.

The block takes single-cycle event strobes from the pipeline and the occupancy of every deferred queue. It returns the phase, the index the ahead thread is filling, the index the behind thread works on, and one-cycle pulses. The pulses mark a committed-checkpoint capture, a speculative-checkpoint capture, a commit, a thread sync and a failure. A restart-source flag tells the fetch unit whether to resume at the ahead thread's PC or at the committed checkpoint. The queue storage and the register datapath sit outside the block.

Top module: `sst_phase_ctl`

## Requirements
- R1: After reset the phase is nonspeculative (code 0), both indices are 0, behind_active_o and flush_o are low and no pulse is asserted.
- R2: In the nonspeculative phase a retirable instruction leaves the phase unchanged. The first deferrable instruction moves the phase to speculative (code 1) at the next edge, pulses arch_ckpt_o for one cycle and sets both indices to 0.
- R3: The behind thread starts only on a data_return strobe while the oldest queue is not empty. If the oldest queue is also the one the ahead thread fills, a speculative checkpoint is taken on the same edge and the ahead index advances. behind_active_o is never high while the two indices are equal.
- R4: While the behind thread is active and the oldest queue count reaches zero, commit_o pulses, the behind index advances and behind_active_o drops.
- R5: When a commit leaves the ahead thread filling the new oldest queue and that queue is not empty, a speculative checkpoint is taken on the same edge.
- R6: In the speculative phase, when all queue counts are zero and no deferral arrives that cycle, sync_o pulses. The phase returns to nonspeculative and restart_src_o is 0 (resume at the ahead PC).
- R7: A queue overflow, a store-queue overflow or a non-cacheable access marks the ahead checkpoint as not committable and enters scout mode (code 2). In scout mode no new checkpoint is taken and deferrals are ignored. When the marked checkpoint becomes the oldest, fail_o pulses with restart_src_o 1 (committed checkpoint).
- R8: A deferred-branch mispredict in the speculative or scout phase pulses fail_o at once with restart_src_o 1. flush_o then stays high for exactly RESTART_CYCLES cycles (phase code 3), after which the phase is nonspeculative.
- R9: A speculative checkpoint is taken on a branch, on a queue nearly-full strobe, or on a deferral once AGE_LIMIT instructions have passed since the last checkpoint. It is refused while all N_CKPT checkpoints are live.
- R10: Checkpoint indices wrap from N_CKPT-1 back to 0.
- R11: At most one of commit_o, sync_o and fail_o pulses in a cycle. A mispredict wins over a sync that is due in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | An instruction is classified by the ahead thread this cycle |
| ins_defer | input | 1 | That instruction is deferrable |
| ins_branch | input | 1 | That instruction is a branch |
| dq_near_full | input | 1 | The ahead thread's queue is nearly full |
| dq_overflow | input | 1 | The ahead thread's queue overflowed |
| sq_overflow | input | 1 | The store queue overflowed |
| nc_access | input | 1 | A non-cacheable access was met |
| br_mispredict | input | 1 | The behind thread resolved a deferred branch as mispredicted |
| data_return | input | 1 | An entry in the oldest queue can now retire |
| dq_count | input | N_CKPT*CNT_W | Occupancy of each queue, queue k in bits [k*CNT_W +: CNT_W] |
| phase_o | output | 2 | 0 nonspeculative, 1 speculative, 2 scout, 3 flush |
| ahead_idx_o | output | IDX_W | Checkpoint index being filled by the ahead thread |
| behind_idx_o | output | IDX_W | Oldest live checkpoint index |
| behind_active_o | output | 1 | Behind thread is draining the oldest queue |
| arch_ckpt_o | output | 1 | Committed checkpoint captured (one cycle) |
| spec_ckpt_o | output | 1 | Speculative checkpoint captured (one cycle) |
| commit_o | output | 1 | Oldest checkpoint committed (one cycle) |
| sync_o | output | 1 | Thread sync performed (one cycle) |
| fail_o | output | 1 | Speculation failed (one cycle) |
| restart_src_o | output | 1 | 0 resume at ahead PC, 1 restart from committed checkpoint |
| flush_o | output | 1 | Pipeline flush in progress |

## Verification
The bench targets the commit edge in a two-entry ring. There the behind index must advance while a forced checkpoint wraps the ahead index back to 0. A design that forgot the forced capture, or that would not reuse the slot freed by the same commit, would leave both indices equal. The bench also drives a sync and a commit that are due in the same cycle, and a mispredict that arrives together with empty queues. Either would show up as the wrong pulse or as two pulses at once. Finally it steps the age counter one short of its limit, checks that an overflowed checkpoint fails only once it becomes the oldest, and counts the flush window to the cycle.

// File: rtl/spc_pkg.sv
package spc_pkg;

   typedef enum logic [1:0] {
      PH_NONSPEC = 2'd0,
      PH_SPEC    = 2'd1,
      PH_SCOUT   = 2'd2,
      PH_FLUSH   = 2'd3
   } phase_e;

   typedef enum logic {
      RS_AHEAD_PC   = 1'b0,
      RS_COMMITTED  = 1'b1
   } rsrc_e;

   typedef struct packed {
      logic enter;    // open ring with one live checkpoint at index 0
      logic take;     // ahead thread moves to next index
      logic commit;   // oldest checkpoint retires
      logic start;    // behind thread begins draining oldest
      logic mark_uc;  // ahead checkpoint becomes non-committable
      logic clear;    // empty the ring
   } ring_cmd_t;

endpackage

// File: rtl/spc_policy.sv
module spc_policy #(
   parameter int AGE_LIMIT      = 30,
   parameter bit CKPT_ON_BRANCH = 1'b1,
   localparam int AGE_W = $clog2(AGE_LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic count_en,
   input  logic age_clr,
   input  logic ins_valid,
   input  logic ins_defer,
   input  logic ins_branch,
   input  logic dq_near_full,
   output logic req_o
);

   initial begin
      assert (AGE_LIMIT >= 1) else $error("spc_policy: AGE_LIMIT must be at least 1");
   end

   logic [AGE_W-1:0] age_q;
   logic             age_hit;
   logic             br_trig;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         age_q <= '0;
      end else if (age_clr) begin
         age_q <= '0;
      end else if (count_en && (age_q < AGE_W'(AGE_LIMIT))) begin
         age_q <= age_q + 1'b1;
      end
   end

   assign age_hit = (age_q >= AGE_W'(AGE_LIMIT));

   generate
      if (CKPT_ON_BRANCH) begin : g_br_on
         assign br_trig = ins_branch;
      end else begin : g_br_off
         assign br_trig = 1'b0;
      end
   endgenerate

   assign req_o = ins_valid && (br_trig || dq_near_full || (ins_defer && age_hit));

   AST_AGE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      age_q <= AGE_W'(AGE_LIMIT)); // R9

endmodule

// File: rtl/spc_ring.sv
module spc_ring
   import spc_pkg::*;
#(
   parameter int N_CKPT = 2,
   localparam int IDX_W  = $clog2(N_CKPT),
   localparam int LIVE_W = $clog2(N_CKPT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ring_cmd_t         cmd,
   output logic [IDX_W-1:0]  oldest_o,
   output logic [IDX_W-1:0]  ahead_o,
   output logic [LIVE_W-1:0] n_live_o,
   output logic              behind_active_o,
   output logic [N_CKPT-1:0] uc_o
);

   logic [IDX_W-1:0]  oldest_q, ahead_q;
   logic [LIVE_W-1:0] live_q;
   logic              behind_q;
   logic [N_CKPT-1:0] uc_q;

   function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] i);
      return (i == IDX_W'(N_CKPT - 1)) ? '0 : i + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oldest_q <= '0;
         ahead_q  <= '0;
         live_q   <= '0;
         behind_q <= 1'b0;
         uc_q     <= '0;
      end else if (cmd.clear) begin
         oldest_q <= '0;
         ahead_q  <= '0;
         live_q   <= '0;
         behind_q <= 1'b0;
         uc_q     <= '0;
      end else if (cmd.enter) begin
         oldest_q <= '0;
         ahead_q  <= '0;
         live_q   <= LIVE_W'(1);
         behind_q <= 1'b0;
         uc_q     <= '0;
      end else begin
         if (cmd.commit) begin
            oldest_q       <= wrap_inc(oldest_q);
            uc_q[oldest_q] <= 1'b0;
         end
         if (cmd.take) begin
            ahead_q <= wrap_inc(ahead_q);
         end
         case ({cmd.take, cmd.commit})
            2'b10:   live_q <= live_q + 1'b1;
            2'b01:   live_q <= live_q - 1'b1;
            default: live_q <= live_q;
         endcase
         if (cmd.commit) begin
            behind_q <= 1'b0;
         end else if (cmd.start) begin
            behind_q <= 1'b1;
         end
         if (cmd.mark_uc) begin
            uc_q[ahead_q] <= 1'b1;
         end
      end
   end

   assign oldest_o        = oldest_q;
   assign ahead_o         = ahead_q;
   assign n_live_o        = live_q;
   assign behind_active_o = behind_q;
   assign uc_o            = uc_q;

   AST_LIVE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      live_q <= LIVE_W'(N_CKPT)); // R9

   AST_TAKE_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.take && !cmd.commit) |-> (live_q < LIVE_W'(N_CKPT))); // R9

   AST_BEHIND_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      behind_q |-> (ahead_q != oldest_q)); // R3

   AST_WRAP_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.commit && !cmd.clear && !cmd.enter && oldest_q == IDX_W'(N_CKPT - 1))
      |=> (oldest_q == '0)); // R10

endmodule

// File: rtl/spc_phase_fsm.sv
module spc_phase_fsm
   import spc_pkg::*;
#(
   parameter int N_CKPT         = 2,
   parameter int RESTART_CYCLES = 24,
   localparam int LIVE_W = $clog2(N_CKPT + 1),
   localparam int FL_W   = $clog2(RESTART_CYCLES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_valid,
   input  logic              ins_defer,
   input  logic              dq_overflow,
   input  logic              sq_overflow,
   input  logic              nc_access,
   input  logic              br_mispredict,
   input  logic              data_return,
   input  logic              all_empty,
   input  logic              oldest_empty,
   input  logic              ahead_empty,
   input  logic [LIVE_W-1:0] n_live,
   input  logic              behind_active,
   input  logic              uc_oldest,
   input  logic              policy_req,
   output ring_cmd_t         cmd_o,
   output logic              age_en_o,
   output phase_e            phase_o,
   output logic              arch_ckpt_o,
   output logic              spec_ckpt_o,
   output logic              commit_o,
   output logic              sync_o,
   output logic              fail_o,
   output rsrc_e             restart_src_o,
   output logic              flush_o
);

   initial begin
      assert (RESTART_CYCLES >= 2) else $error("spc_phase_fsm: RESTART_CYCLES must be at least 2");
   end

   phase_e           phase_q;
   logic [FL_W-1:0]  fl_cnt_q;
   rsrc_e            rsrc_q;
   logic             arch_q, spec_q, commit_q, sync_q, fail_q;

   logic in_spec, in_scout, spec_like, defer_in, hazard;
   logic fail_now, sync_now, live_ok, commit_now, start_now;
   logic room, can_take, forced_take, start_take, take_now, start_ok;
   logic mark_now, enter_now;

   assign in_spec   = (phase_q == PH_SPEC);
   assign in_scout  = (phase_q == PH_SCOUT);
   assign spec_like = in_spec || in_scout;
   assign defer_in  = ins_valid && ins_defer;
   assign hazard    = dq_overflow || sq_overflow || nc_access;

   // priority: failure, then sync, then commit/start/take
   assign fail_now   = spec_like && (br_mispredict || uc_oldest);
   assign sync_now   = in_spec && !fail_now && all_empty && !defer_in;
   assign live_ok    = spec_like && !fail_now && !sync_now;
   assign commit_now = live_ok && behind_active && oldest_empty;
   assign start_now  = live_ok && !commit_now && !behind_active && data_return && !oldest_empty;

   assign room        = (n_live < LIVE_W'(N_CKPT)) || commit_now;
   assign can_take    = in_spec && live_ok && !hazard;
   assign forced_take = commit_now && (n_live == LIVE_W'(2)) && !ahead_empty;
   assign start_take  = start_now && (n_live == LIVE_W'(1));
   assign take_now    = can_take && room && (forced_take || start_take || policy_req);
   assign start_ok    = start_now && ((n_live > LIVE_W'(1)) || take_now);
   assign mark_now    = in_spec && live_ok && hazard;
   assign enter_now   = (phase_q == PH_NONSPEC) && defer_in;

   always_comb begin
      cmd_o         = '0;
      cmd_o.enter   = enter_now;
      cmd_o.take    = take_now;
      cmd_o.commit  = commit_now;
      cmd_o.start   = start_ok;
      cmd_o.mark_uc = mark_now;
      cmd_o.clear   = fail_now || sync_now;
   end

   assign age_en_o = in_spec && ins_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_NONSPEC;
         fl_cnt_q <= '0;
      end else begin
         case (phase_q)
            PH_NONSPEC: begin
               if (enter_now) phase_q <= PH_SPEC;
            end
            PH_SPEC, PH_SCOUT: begin
               if (fail_now) begin
                  phase_q  <= PH_FLUSH;
                  fl_cnt_q <= FL_W'(RESTART_CYCLES - 1);
               end else if (sync_now) begin
                  phase_q <= PH_NONSPEC;
               end else if (mark_now) begin
                  phase_q <= PH_SCOUT;
               end
            end
            default: begin
               if (fl_cnt_q == '0) begin
                  phase_q <= PH_NONSPEC;
               end else begin
                  fl_cnt_q <= fl_cnt_q - 1'b1;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arch_q   <= 1'b0;
         spec_q   <= 1'b0;
         commit_q <= 1'b0;
         sync_q   <= 1'b0;
         fail_q   <= 1'b0;
         rsrc_q   <= RS_AHEAD_PC;
      end else begin
         arch_q   <= enter_now;
         spec_q   <= take_now;
         commit_q <= commit_now;
         sync_q   <= sync_now;
         fail_q   <= fail_now;
         if (fail_now) begin
            rsrc_q <= RS_COMMITTED;
         end else if (sync_now) begin
            rsrc_q <= RS_AHEAD_PC;
         end
      end
   end

   assign phase_o       = phase_q;
   assign arch_ckpt_o   = arch_q;
   assign spec_ckpt_o   = spec_q;
   assign commit_o      = commit_q;
   assign sync_o        = sync_q;
   assign fail_o        = fail_q;
   assign restart_src_o = rsrc_q;
   assign flush_o       = (phase_q == PH_FLUSH);

   AST_ENTER_SPEC: assert property (@(posedge clk) disable iff (!rst_n)
      enter_now |=> (phase_q == PH_SPEC)); // R2

   AST_EVT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({commit_q, sync_q, fail_q})); // R11

   AST_FAIL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      fail_now |=> (flush_o && fail_q && rsrc_q == RS_COMMITTED)); // R8

   AST_FLUSH_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flush_o) |-> (phase_q == PH_NONSPEC)); // R8

   AST_SCOUT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      in_scout |-> !cmd_o.take); // R7

   AST_SYNC_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      sync_q |-> (phase_q == PH_NONSPEC && rsrc_q == RS_AHEAD_PC)); // R6

endmodule

// File: rtl/sst_phase_ctl.sv
module sst_phase_ctl
   import spc_pkg::*;
#(
   parameter int N_CKPT         = 2,
   parameter int DQ_DEPTH       = 32,
   parameter int AGE_LIMIT      = 30,
   parameter int RESTART_CYCLES = 24,
   parameter bit CKPT_ON_BRANCH = 1'b1,
   localparam int IDX_W = $clog2(N_CKPT),
   localparam int CNT_W = $clog2(DQ_DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ins_valid,
   input  logic                    ins_defer,
   input  logic                    ins_branch,
   input  logic                    dq_near_full,
   input  logic                    dq_overflow,
   input  logic                    sq_overflow,
   input  logic                    nc_access,
   input  logic                    br_mispredict,
   input  logic                    data_return,
   input  logic [N_CKPT*CNT_W-1:0] dq_count,
   output logic [1:0]              phase_o,
   output logic [IDX_W-1:0]        ahead_idx_o,
   output logic [IDX_W-1:0]        behind_idx_o,
   output logic                    behind_active_o,
   output logic                    arch_ckpt_o,
   output logic                    spec_ckpt_o,
   output logic                    commit_o,
   output logic                    sync_o,
   output logic                    fail_o,
   output logic                    restart_src_o,
   output logic                    flush_o
);

   localparam int LIVE_W = $clog2(N_CKPT + 1);

   initial begin
      assert (N_CKPT >= 2) else $error("sst_phase_ctl: N_CKPT must be at least 2");
      assert (DQ_DEPTH >= 2) else $error("sst_phase_ctl: DQ_DEPTH must be at least 2");
   end

   ring_cmd_t         cmd;
   logic [IDX_W-1:0]  oldest, ahead;
   logic [LIVE_W-1:0] n_live;
   logic              behind_active;
   logic [N_CKPT-1:0] uc_vec;
   logic [N_CKPT-1:0] nz_vec;
   logic              age_en, policy_req;
   phase_e            phase;
   rsrc_e             rsrc;

   generate
      for (genvar k = 0; k < N_CKPT; k++) begin : g_occ
         assign nz_vec[k] = |dq_count[k*CNT_W +: CNT_W];
      end
   endgenerate

   spc_ring #(.N_CKPT(N_CKPT)) u_ring (
      .clk             (clk),
      .rst_n           (rst_n),
      .cmd             (cmd),
      .oldest_o        (oldest),
      .ahead_o         (ahead),
      .n_live_o        (n_live),
      .behind_active_o (behind_active),
      .uc_o            (uc_vec)
   );

   spc_policy #(.AGE_LIMIT(AGE_LIMIT), .CKPT_ON_BRANCH(CKPT_ON_BRANCH)) u_policy (
      .clk          (clk),
      .rst_n        (rst_n),
      .count_en     (age_en),
      .age_clr      (cmd.enter || cmd.take),
      .ins_valid    (ins_valid),
      .ins_defer    (ins_defer),
      .ins_branch   (ins_branch),
      .dq_near_full (dq_near_full),
      .req_o        (policy_req)
   );

   spc_phase_fsm #(.N_CKPT(N_CKPT), .RESTART_CYCLES(RESTART_CYCLES)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .ins_valid     (ins_valid),
      .ins_defer     (ins_defer),
      .dq_overflow   (dq_overflow),
      .sq_overflow   (sq_overflow),
      .nc_access     (nc_access),
      .br_mispredict (br_mispredict),
      .data_return   (data_return),
      .all_empty     (~|nz_vec),
      .oldest_empty  (~nz_vec[oldest]),
      .ahead_empty   (~nz_vec[ahead]),
      .n_live        (n_live),
      .behind_active (behind_active),
      .uc_oldest     (uc_vec[oldest]),
      .policy_req    (policy_req),
      .cmd_o         (cmd),
      .age_en_o      (age_en),
      .phase_o       (phase),
      .arch_ckpt_o   (arch_ckpt_o),
      .spec_ckpt_o   (spec_ckpt_o),
      .commit_o      (commit_o),
      .sync_o        (sync_o),
      .fail_o        (fail_o),
      .restart_src_o (rsrc),
      .flush_o       (flush_o)
   );

   assign phase_o         = phase;
   assign restart_src_o   = rsrc;
   assign ahead_idx_o     = ahead;
   assign behind_idx_o    = oldest;
   assign behind_active_o = behind_active;

   AST_NONSPEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_NONSPEC) |-> (!behind_active && n_live == '0)); // R1

   AST_COMMIT_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> (oldest != $past(oldest))); // R4

endmodule

// File: tb/sst_phase_ctl_test.sv
`timescale 1ns/1ps
module sst_phase_ctl_test;

   localparam int N   = 2;
   localparam int CW  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ins_valid = 0, ins_defer = 0, ins_branch = 0, dq_near_full = 0;
   logic dq_overflow = 0, sq_overflow = 0, nc_access = 0, br_mispredict = 0, data_return = 0;
   logic [N*CW-1:0] dq_count = '0;
   logic [1:0] phase_o;
   logic       ahead_idx_o, behind_idx_o;
   logic       behind_active_o, arch_ckpt_o, spec_ckpt_o, commit_o, sync_o, fail_o;
   logic       restart_src_o, flush_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   sst_phase_ctl uut (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_defer(ins_defer),
      .ins_branch(ins_branch), .dq_near_full(dq_near_full), .dq_overflow(dq_overflow),
      .sq_overflow(sq_overflow), .nc_access(nc_access), .br_mispredict(br_mispredict),
      .data_return(data_return), .dq_count(dq_count), .phase_o(phase_o),
      .ahead_idx_o(ahead_idx_o), .behind_idx_o(behind_idx_o),
      .behind_active_o(behind_active_o), .arch_ckpt_o(arch_ckpt_o),
      .spec_ckpt_o(spec_ckpt_o), .commit_o(commit_o), .sync_o(sync_o), .fail_o(fail_o),
      .restart_src_o(restart_src_o), .flush_o(flush_o)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic quiet();
      ins_valid = 0; ins_defer = 0; ins_branch = 0; dq_near_full = 0;
      dq_overflow = 0; sq_overflow = 0; nc_access = 0; br_mispredict = 0; data_return = 0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      quiet();
   endtask

   task automatic set_cnt(input int q, input int v);
      dq_count[q*CW +: CW] = CW'(v);
   endtask

   task automatic do_reset();
      @(negedge clk);
      quiet();
      dq_count = '0;
      rst_n = 0;
      step();
      step();
      rst_n = 1;
   endtask

   task automatic enter_spec();
      ins_valid = 1; ins_defer = 1; set_cnt(0, 1);
      step();
   endtask

   // R1
   task automatic t_reset();
      do_reset();
      check("R1", "phase", phase_o, 0);
      check("R1", "ahead idx", ahead_idx_o, 0);
      check("R1", "behind idx", behind_idx_o, 0);
      check("R1", "flush", flush_o, 0);
      check("R1", "pulses", {commit_o, sync_o, fail_o, arch_ckpt_o, spec_ckpt_o, behind_active_o}, 0);
   endtask

   // R2
   task automatic t_enter();
      do_reset();
      ins_valid = 1; ins_defer = 0;
      step();
      check("R2", "retirable keeps nonspec", phase_o, 0);
      check("R2", "no checkpoint on retirable", arch_ckpt_o, 0);
      enter_spec();
      check("R2", "phase after first deferral", phase_o, 1);
      check("R2", "committed checkpoint pulse", arch_ckpt_o, 1);
      check("R2", "ahead idx on entry", ahead_idx_o, 0);
      step();
      check("R2", "checkpoint pulse is one cycle", arch_ckpt_o, 0);
   endtask

   // R3 R4 R5 R10
   task automatic t_drain_commit();
      do_reset();
      enter_spec();
      step();
      check("R3", "behind idle without data return", behind_active_o, 0);
      data_return = 1;
      step();
      check("R3", "checkpoint taken before drain", spec_ckpt_o, 1);
      check("R3", "ahead idx moved", ahead_idx_o, 1);
      check("R3", "behind active", behind_active_o, 1);
      check("R3", "behind idx", behind_idx_o, 0);
      set_cnt(1, 3);
      step();
      check("R4", "no commit while oldest busy", commit_o, 0);
      set_cnt(0, 0);
      step();
      check("R4", "commit pulse", commit_o, 1);
      check("R4", "behind idx advanced", behind_idx_o, 1);
      check("R4", "behind idle after commit", behind_active_o, 0);
      check("R5", "forced checkpoint pulse", spec_ckpt_o, 1);
      check("R10", "ahead idx wrapped", ahead_idx_o, 0);
      check("R5", "phase stays speculative", phase_o, 1);
   endtask

   // R6
   task automatic t_sync();
      do_reset();
      enter_spec();
      data_return = 1;
      step();
      set_cnt(0, 0); set_cnt(1, 0);
      step();
      check("R6", "sync pulse", sync_o, 1);
      check("R6", "sync wins over commit", commit_o, 0);
      check("R6", "phase nonspec", phase_o, 0);
      check("R6", "restart at ahead pc", restart_src_o, 0);
      check("R6", "ahead idx cleared", ahead_idx_o, 0);
   endtask

   // R9
   task automatic t_policy();
      do_reset();
      enter_spec();
      ins_valid = 1; dq_near_full = 1;
      step();
      check("R9", "near-full checkpoint", spec_ckpt_o, 1);
      check("R9", "ahead idx after near-full", ahead_idx_o, 1);
      ins_valid = 1; ins_branch = 1;
      step();
      check("R9", "checkpoint refused when ring full", spec_ckpt_o, 0);
      check("R9", "ahead idx held when full", ahead_idx_o, 1);
      do_reset();
      enter_spec();
      for (int i = 0; i < 29; i++) begin
         ins_valid = 1;
         step();
      end
      ins_valid = 1; ins_defer = 1;
      step();
      check("R9", "deferral below age limit", ahead_idx_o, 0);
      ins_valid = 1; ins_defer = 1;
      step();
      check("R9", "deferral at age limit", ahead_idx_o, 1);
   endtask

   // R7
   task automatic t_scout();
      do_reset();
      enter_spec();
      ins_valid = 1; ins_branch = 1;
      step();
      set_cnt(1, 1);
      sq_overflow = 1;
      step();
      check("R7", "scout phase", phase_o, 2);
      ins_valid = 1; ins_branch = 1;
      step();
      check("R7", "no checkpoint in scout", spec_ckpt_o, 0);
      ins_valid = 1; ins_defer = 1;
      step();
      check("R7", "deferral ignored in scout", phase_o, 2);
      check("R7", "ahead idx unchanged in scout", ahead_idx_o, 1);
      data_return = 1;
      step();
      check("R7", "behind drains older checkpoint", behind_active_o, 1);
      set_cnt(0, 0);
      step();
      check("R7", "older checkpoint commits", commit_o, 1);
      check("R7", "no fail yet", fail_o, 0);
      step();
      check("R7", "fail when marked is oldest", fail_o, 1);
      check("R7", "restart from committed", restart_src_o, 1);
      check("R7", "flush phase", phase_o, 3);
   endtask

   // R8 R11
   task automatic t_mispredict();
      int n_fl;
      do_reset();
      enter_spec();
      set_cnt(0, 0);
      br_mispredict = 1;
      step();
      check("R11", "mispredict beats sync", sync_o, 0);
      check("R8", "fail pulse", fail_o, 1);
      check("R8", "restart from committed", restart_src_o, 1);
      check("R8", "flush raised", flush_o, 1);
      n_fl = 1;
      for (int i = 0; i < 100; i++) begin
         if (!flush_o) break;
         ins_valid = 1; ins_defer = 1;
         step();
         if (flush_o) n_fl++;
      end
      check("R8", "flush length", n_fl, 24);
      check("R8", "nonspec after flush", phase_o, 0);
   endtask

   initial begin
      #(5.0 * 100000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_enter();
      t_drain_commit();
      t_sync();
      t_policy();
      t_scout();
      t_mispredict();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule